// File: doc/BRIEF.md
# Multi-Lane Synthesizer Profile Loader

This block loads a new frequency, phase and amplitude setting into several direct digital synthesizer channels in one serial transfer. All channels share a single chip-select line and a single serial clock; each channel has a private data line. Every channel receives a frame of the same layout at the same time. When the frame is complete, one strobe tells all channels to apply their new settings together, so their outputs change in the same cycle.

A one-cycle start pulse begins a transfer and captures one 64-bit profile word per channel. A done flag is low while the transfer runs and high when the block can accept the next start. The serial clock rate is set at build time. The parameter `SCK_DIV` gives the number of system cycles in each serial clock phase, and its smallest value is 1.

Top module: `dds_lane_writer`

## Requirements
- R1: After reset, chip select (`cs_n_o`) is high, the serial clock is low, all data lines are low, the update strobe is low and `done_o` is high.
- R2: A start pulse accepted while `done_o` is high makes `done_o` low from the next cycle. It stays low until the cycle after the update strobe, when it returns high.
- R3: Each lane frame is 72 bits long and goes out most significant bit first. It holds the command byte 0x0E, then a 32-bit frequency word, then a 16-bit phase word, then a 16-bit amplitude word.
- R4: Each lane's 64-bit profile slice (lane n at bits 64n+63 down to 64n) holds the frequency word in [63:32], the phase word in [31:16] and the amplitude word in [15:0]. Lane n's data line carries only its own slice.
- R5: The serial clock is high for `SCK_DIV` cycles, then low for `SCK_DIV` cycles, for each bit. It pulses only while chip select is low, so exactly 72 falling edges occur in a transfer.
- R6: Each data line changes only on the cycle in which the serial clock rises or chip select changes. Its value is therefore stable across every falling edge.
- R7: Chip select goes high `SCK_DIV` cycles after the last falling edge. The update strobe is high for exactly one cycle, the cycle after chip select rises.
- R8: Profile words are captured at start. Changing them during a transfer does not change the bits sent.
- R9: A start pulse while `done_o` is low is ignored. The transfer in progress keeps its timing and content.
- R10: `SCK_DIV` = 1 gives a serial clock of half the system rate, with 144 cycles from the first rising edge to chip select rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to send a frame |
| profile_i | input | 64*LANES | Packed profile words, one 64-bit slice per lane |
| sclk_o | output | 1 | Shared serial clock |
| cs_n_o | output | 1 | Shared active-low chip select |
| mosi_o | output | LANES | Serial data, one line per lane |
| io_update_o | output | 1 | One-cycle strobe that applies the new profiles |
| done_o | output | 1 | High when idle and ready for a start |

## Verification
The bench runs two instances, one with `SCK_DIV` = 1 and one with `SCK_DIV` = 3, against a timing model that counts cycles from the accepted start. A separate receiver model shifts in each data line on serial clock falls, and the frame it collects is compared when the strobe appears. Stimulus rewrites the profiles in the middle of a transfer and pulses start while the block is busy, including in the tail cycles after chip select has risen. A design that read the live profiles instead of the captured ones would deliver a mixed frame. A design that restarted on the extra pulses would show `done_o`, chip select or the clock out of step with the model. The bench also holds start high across the end of a transfer. This catches an off-by-one in the bit or phase counter, which would show up as 71 or 73 falls or a stretched strobe. It also catches a data change on the falling edge, which would make the receiver capture shifted bits.

// File: rtl/dds_lw_pkg.sv
package dds_lw_pkg;
  localparam int PROF_W  = 64;
  localparam int CMD_W   = 8;
  localparam int FRAME_W = CMD_W + PROF_W;
  localparam logic [CMD_W-1:0] CMD_WRITE = 8'h0E;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_STRB  = 2'd2,
    SEQ_TAIL  = 2'd3
  } seq_state_t;

  function automatic logic [FRAME_W-1:0] build_frame(input logic [PROF_W-1:0] prof);
    return {CMD_WRITE, prof};
  endfunction
endpackage

// File: rtl/dds_lw_sequencer.sv
module dds_lw_sequencer
  import dds_lw_pkg::*;
#(
  parameter int SCK_DIV = 1,
  parameter int BITS    = FRAME_W
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic shift_o,
  output logic clear_o,
  output logic sclk_o,
  output logic cs_n_o,
  output logic upd_o,
  output logic done_o
);
  localparam int PER = 2 * SCK_DIV;
  localparam int CW  = (PER > 1) ? $clog2(PER) : 1;
  localparam int BW  = $clog2(BITS);
  localparam logic [CW-1:0] FALL_AT = CW'(SCK_DIV - 1);
  localparam logic [CW-1:0] LAST_AT = CW'(PER - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(BITS - 1);

  seq_state_t state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic bit_end;

  assign bit_end = (state == SEQ_SHIFT) && (cnt == LAST_AT);
  assign load_o  = (state == SEQ_IDLE) && start_i;
  assign shift_o = bit_end && (bitn != LAST_BIT);
  assign clear_o = bit_end && (bitn == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SEQ_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      sclk_o <= 1'b0;
      cs_n_o <= 1'b1;
      upd_o  <= 1'b0;
      done_o <= 1'b1;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (start_i) begin
            state  <= SEQ_SHIFT;
            cnt    <= '0;
            bitn   <= '0;
            sclk_o <= 1'b1;
            cs_n_o <= 1'b0;
            done_o <= 1'b0;
          end
        end
        SEQ_SHIFT: begin
          if (cnt == FALL_AT) sclk_o <= 1'b0;
          if (cnt == LAST_AT) begin
            cnt <= '0;
            if (bitn == LAST_BIT) begin
              cs_n_o <= 1'b1;
              state  <= SEQ_STRB;
            end else begin
              bitn   <= bitn + 1'b1;
              sclk_o <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_STRB: begin
          upd_o <= 1'b1;
          state <= SEQ_TAIL;
        end
        default: begin
          upd_o  <= 1'b0;
          done_o <= 1'b1;
          state  <= SEQ_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dds_lw_lane.sv
module dds_lw_lane
  import dds_lw_pkg::*;
#(
  parameter int BITS = FRAME_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic            shift_i,
  input  logic            clear_i,
  input  logic [BITS-1:0] frame_i,
  output logic            mosi_o
);
  logic [BITS-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)          sr <= '0;
    else if (load_i)  sr <= frame_i;
    else if (shift_i) sr <= {sr[BITS-2:0], 1'b0};
    else if (clear_i) sr <= '0;
  end

  assign mosi_o = sr[BITS-1];
endmodule

// File: rtl/dds_lane_writer.sv
module dds_lane_writer
  import dds_lw_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int SCK_DIV = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [LANES*PROF_W-1:0] profile_i,
  output logic                  sclk_o,
  output logic                  cs_n_o,
  output logic [LANES-1:0]      mosi_o,
  output logic                  io_update_o,
  output logic                  done_o
);
  logic load, shift, clear;

  dds_lw_sequencer #(.SCK_DIV(SCK_DIV), .BITS(FRAME_W)) seq_u (
    .clk(clk), .rst(rst), .start_i(start_i),
    .load_o(load), .shift_o(shift), .clear_o(clear),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .upd_o(io_update_o), .done_o(done_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dds_lw_lane #(.BITS(FRAME_W)) lane_u (
      .clk(clk), .rst(rst),
      .load_i(load), .shift_i(shift), .clear_i(clear),
      .frame_i(build_frame(profile_i[g*PROF_W +: PROF_W])),
      .mosi_o(mosi_o[g])
    );
  end
endmodule

// File: rtl/dds_lw_checker.sv
module dds_lw_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             sclk_o,
  input logic             cs_n_o,
  input logic [LANES-1:0] mosi_o,
  input logic             io_update_o,
  input logic             done_o
);
  // R2
  start_drops_done_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && done_o) |=> !done_o);
  // R2
  strobe_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    io_update_o |=> done_o);
  // R5
  sclk_inside_cs_chk: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> !cs_n_o);
  // R6
  data_stable_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> $stable(mosi_o));
  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    io_update_o |=> !io_update_o);
  // R7
  strobe_after_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(io_update_o) |-> (cs_n_o && $past(cs_n_o)));
endmodule

bind dds_lane_writer dds_lw_checker #(.LANES(LANES)) chk_u (
  .clk(clk), .rst(rst), .start_i(start_i), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
  .mosi_o(mosi_o), .io_update_o(io_update_o), .done_o(done_o)
);

// File: tb/dds_lane_writer_tb_top.sv
module lw_ref_monitor #(
  parameter int LANES = 4,
  parameter int DIV   = 1,
  parameter string TAG = "x"
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [LANES*64-1:0] prof,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic [LANES-1:0]    mosi,
  input  logic                upd,
  input  logic                done,
  output int                  n_cmp,
  output int                  n_bad
);
  localparam int SHIFT_END = 144 * DIV;
  localparam int END_T     = SHIFT_END + 1;
  int t;
  bit armed;
  logic [71:0] frames [LANES];
  logic [71:0] rx [LANES];
  int falls;
  logic prev_sclk;

  initial begin
    t = -1; armed = 0; n_cmp = 0; n_bad = 0; falls = 0; prev_sclk = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      t = -1; armed = 1;
    end else if (t < 0) begin
      if (start) begin
        t = 0;
        for (int l = 0; l < LANES; l++) frames[l] = {8'h0E, prof[l*64 +: 64]};
      end
    end else if (t == END_T) t = -1;
    else t = t + 1;
  end

  task automatic cmp(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h at %0t", req, TAG, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      logic e_cs, e_sclk, e_upd, e_done;
      logic [LANES-1:0] e_mosi;
      string rq;
      e_done = (t < 0);
      e_cs   = !(t >= 0 && t < SHIFT_END);
      e_sclk = (t >= 0 && t < SHIFT_END) && ((t % (2*DIV)) < DIV);
      e_upd  = (t == END_T);
      for (int l = 0; l < LANES; l++)
        e_mosi[l] = (t >= 0 && t < SHIFT_END) ? frames[l][71 - t/(2*DIV)] : 1'b0;
      rq = rst ? "R1" : "R2";
      cmp(rq, "done", done, e_done);
      rq = rst ? "R1" : "R7";
      cmp(rq, "cs_n", cs_n, e_cs);
      cmp(rq, "io_update", upd, e_upd);
      rq = rst ? "R1" : ((DIV == 1) ? "R10" : "R5");
      cmp(rq, "sclk", sclk, e_sclk);
      rq = rst ? "R1" : "R6";
      cmp(rq, "mosi", mosi, e_mosi);
      // receiver: sample each lane on a falling serial clock while selected
      if (prev_sclk && !sclk && !cs_n) begin
        for (int l = 0; l < LANES; l++) rx[l] = {rx[l][70:0], mosi[l]};
        falls++;
      end
      if (upd) begin
        cmp("R5", "fall count", falls, 72);
        for (int l = 0; l < LANES; l++)
          cmp((l == 0) ? "R3" : "R4", $sformatf("frame lane %0d", l), rx[l], frames[l]);
        falls = 0;
      end
      prev_sclk = sclk;
    end
  end
endmodule

module dds_lane_writer_tb_top;
  localparam int LANES = 4;
  logic clk = 0;
  logic rst = 1;
  logic start = 0;
  logic [LANES*64-1:0] prof = '0;

  logic sclk_a, cs_a, upd_a, done_a, sclk_b, cs_b, upd_b, done_b;
  logic [LANES-1:0] mosi_a, mosi_b;
  int ca, ba, cb, bb;
  int wd_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dds_lane_writer #(.LANES(LANES), .SCK_DIV(1)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .profile_i(prof),
    .sclk_o(sclk_a), .cs_n_o(cs_a), .mosi_o(mosi_a), .io_update_o(upd_a), .done_o(done_a));
  dds_lane_writer #(.LANES(LANES), .SCK_DIV(3)) dut_b (
    .clk(clk), .rst(rst), .start_i(start), .profile_i(prof),
    .sclk_o(sclk_b), .cs_n_o(cs_b), .mosi_o(mosi_b), .io_update_o(upd_b), .done_o(done_b));

  lw_ref_monitor #(.LANES(LANES), .DIV(1), .TAG("div1")) mon_a (
    .clk(clk), .rst(rst), .start(start), .prof(prof), .sclk(sclk_a), .cs_n(cs_a),
    .mosi(mosi_a), .upd(upd_a), .done(done_a), .n_cmp(ca), .n_bad(ba));
  lw_ref_monitor #(.LANES(LANES), .DIV(3), .TAG("div3")) mon_b (
    .clk(clk), .rst(rst), .start(start), .prof(prof), .sclk(sclk_b), .cs_n(cs_b),
    .mosi(mosi_b), .upd(upd_b), .done(done_b), .n_cmp(cb), .n_bad(bb));

  task automatic set_prof(input int seed);
    for (int l = 0; l < LANES; l++)
      prof[l*64 +: 64] = {32'hA5000000 ^ (seed * 32'h01010101) ^ l, 16'h3000 | 16'(seed + l),
                          16'h1F00 ^ 16'(l << 4 | seed)};
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    while (!(done_a && done_b)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ca + cb + 1, ba + bb + wd_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;                                   // R1 reset values checked while rst high
    repeat (2) @(negedge clk);
    // R3 R4 distinct profiles per lane
    set_prof(1); pulse_start(); wait_idle();
    // R8 profiles rewritten mid-transfer
    set_prof(2); pulse_start();
    repeat (20) @(negedge clk); set_prof(9);
    wait_idle();
    // R9 extra start pulses while busy, including tail cycles
    set_prof(3); pulse_start();
    repeat (30) @(negedge clk); pulse_start();
    while (!upd_a) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait_idle();
    // R2 start held high across the end of a transfer
    set_prof(4); @(negedge clk); start = 1;
    repeat (1000) @(negedge clk);
    start = 0;
    wait_idle();
    // all-ones and all-zero profiles
    prof = '1; pulse_start(); wait_idle();
    prof = '0; pulse_start(); wait_idle();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule